// File: doc/BRIEF.md
# Frame-Size-Dependent Dual FIFO

This block holds the two data queues of a serial controller: a transmit lane that collects words waiting to be shifted out, and a receive lane that holds words that have been shifted in. Each lane stores 32-bit words in 32 physical slots. The number of slots a lane may actually use is its effective depth, and it is chosen at run time. A big-queue enable selects it, and so does the programmed frame width, which ranges from 0 to 63 bits.

Each lane has a valid/ready write side and a valid/ready read side. On the write side, a word is accepted only in a cycle where `*_in_valid` and `*_in_ready` are both high. Ready falls as soon as the occupancy reaches the effective depth, and a word offered while ready is low is discarded. Ready does not depend on a pop in the same cycle. On the read side, `*_out_valid` is high whenever the lane holds a word, and the head word is removed in a cycle where `*_out_valid` and `*_out_ready` are both high. Each lane also has a synchronous flush and four occupancy flags.

Top module: `dual_frame_fifo`

## Requirements
- R1: After reset both lanes are empty: empty is 1, empty-next, full and full-next are 0, in_ready is 1 and out_valid is 0.
- R2: With `cfg_big_fifo` = 0 the effective depth of each lane is 4 words, whatever the frame width.
- R3: With `cfg_big_fifo` = 1 the effective depth is 32 words for `cfg_frame_bits` <= 8, 16 words for 9 to 16, and 8 words for 17 and above.
- R4: When the occupancy is at or above the effective depth, in_ready is 0 and an offered word is discarded: occupancy and stored contents are unchanged.
- R5: full-next is 1 exactly when the occupancy equals depth minus one. full is 1 when the occupancy is at or above the depth.
- R6: empty is 1 exactly when the occupancy is 0. empty-next is 1 exactly when the occupancy is 1, so popping the last word raises empty.
- R7: A flush empties the lane at the next edge: empty rises and full falls. A flush takes priority over a push or pop in the same cycle.
- R8: While a lane is empty, out_valid is 0 and out_data is zero, and asserting out_ready changes nothing.
- R9: Words leave in the order they were accepted. A push and a pop in the same cycle both take effect, leaving the occupancy unchanged.
- R10: If the depth is lowered below the current occupancy, all stored words are kept, full reads 1 and in_ready stays 0 until the occupancy falls below the new depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_fifo | input | 1 | Enables the frame-dependent large depth |
| cfg_frame_bits | input | 6 | Programmed frame width in bits |
| tx_flush | input | 1 | Synchronous clear of the transmit lane |
| tx_in_valid | input | 1 | Transmit write word offered |
| tx_in_ready | output | 1 | Transmit lane below its depth |
| tx_in_data | input | 32 | Transmit write word |
| tx_out_valid | output | 1 | Transmit head word present |
| tx_out_ready | input | 1 | Consumer takes the transmit head |
| tx_out_data | output | 32 | Transmit head word, zero when empty |
| tx_empty | output | 1 | Transmit occupancy is 0 |
| tx_empty_nxt | output | 1 | Transmit occupancy is 1 |
| tx_full | output | 1 | Transmit occupancy at or above depth |
| tx_full_nxt | output | 1 | Transmit occupancy is depth minus one |
| rx_flush | input | 1 | Synchronous clear of the receive lane |
| rx_in_valid | input | 1 | Receive write word offered |
| rx_in_ready | output | 1 | Receive lane below its depth |
| rx_in_data | input | 32 | Receive write word |
| rx_out_valid | output | 1 | Receive head word present |
| rx_out_ready | input | 1 | Consumer takes the receive head |
| rx_out_data | output | 32 | Receive head word, zero when empty |
| rx_empty | output | 1 | Receive occupancy is 0 |
| rx_empty_nxt | output | 1 | Receive occupancy is 1 |
| rx_full | output | 1 | Receive occupancy at or above depth |
| rx_full_nxt | output | 1 | Receive occupancy is depth minus one |

## Verification
Pushes, pops and flushes act at the clock edge that samples the handshake. The flags, in_ready, out_valid and the head word reflect that edge within the same cycle, so the bench drives one time unit after a rising edge and samples at the following falling edge. A change of the depth inputs alters in_ready and the full flags combinationally, in the cycle of the change with no edge in between, and the bench checks this at the next falling edge. The scoreboard monitor compares a popped word at the falling edge before the edge that removes it, one time unit after the driver has made its own ready check, so a push and a pop in the same cycle are counted in a fixed order.

// File: rtl/dff_pkg.sv
package dff_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic empty;
    logic empty_nxt;
    logic full;
    logic full_nxt;
  } lane_flags_t;
endpackage

// File: rtl/dff_depth_sel.sv
module dff_depth_sel #(
  parameter int SLOTS       = 32,
  parameter int FSZ_W       = 6,
  parameter int SMALL_DEPTH = 4,
  parameter int BYTE_LIMIT  = 8,
  parameter int HALF_LIMIT  = 16,
  parameter int CNT_W       = $clog2(SLOTS + 1)
) (
  input  logic             big_en,
  input  logic [FSZ_W-1:0] frame_bits,
  output logic [CNT_W-1:0] depth
);
  localparam logic [FSZ_W-1:0] BYTE_LIM = FSZ_W'(BYTE_LIMIT);
  localparam logic [FSZ_W-1:0] HALF_LIM = FSZ_W'(HALF_LIMIT);
  localparam logic [CNT_W-1:0] D_SMALL  = CNT_W'(SMALL_DEPTH);
  localparam logic [CNT_W-1:0] D_FULL   = CNT_W'(SLOTS);
  localparam logic [CNT_W-1:0] D_HALF   = CNT_W'(SLOTS / 2);
  localparam logic [CNT_W-1:0] D_QUART  = CNT_W'(SLOTS / 4);

  always_comb begin
    if (!big_en)                   depth = D_SMALL;
    else if (frame_bits <= BYTE_LIM) depth = D_FULL;
    else if (frame_bits <= HALF_LIM) depth = D_HALF;
    else                           depth = D_QUART;
  end
endmodule

// File: rtl/dff_lane.sv
module dff_lane #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 32,
  parameter int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [CNT_W-1:0]  depth,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = $clog2(SLOTS);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

  logic [DATA_W-1:0] mem [SLOTS];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push, pop;

  assign in_ready  = count < depth;
  assign out_valid = count != '0;
  assign out_data  = out_valid ? mem[rd_ptr] : '0;
  assign push      = in_valid && in_ready && !flush;
  assign pop       = out_valid && out_ready && !flush;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dff_flags.sv
module dff_flags
  import dff_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] depth,
  output lane_flags_t      flags
);
  always_comb begin
    flags.empty     = count == '0;
    flags.empty_nxt = count == CNT_W'(1);
    flags.full      = count >= depth;
    flags.full_nxt  = count == (depth - CNT_W'(1));
  end
endmodule

// File: rtl/dual_frame_fifo.sv
module dual_frame_fifo
  import dff_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SLOTS       = 32,
  parameter int FSZ_W       = 6,
  parameter int SMALL_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_fifo,
  input  logic [FSZ_W-1:0]  cfg_frame_bits,
  input  logic              tx_flush,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              tx_empty,
  output logic              tx_empty_nxt,
  output logic              tx_full,
  output logic              tx_full_nxt,
  input  logic              rx_flush,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_empty,
  output logic              rx_empty_nxt,
  output logic              rx_full,
  output logic              rx_full_nxt
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0]  depth;
  logic              l_flush     [LANES];
  logic              l_in_valid  [LANES];
  logic              l_in_ready  [LANES];
  logic [DATA_W-1:0] l_in_data   [LANES];
  logic              l_out_valid [LANES];
  logic              l_out_ready [LANES];
  logic [DATA_W-1:0] l_out_data  [LANES];
  logic [CNT_W-1:0]  l_count     [LANES];
  lane_flags_t       l_flags     [LANES];

  dff_depth_sel #(
    .SLOTS(SLOTS), .FSZ_W(FSZ_W), .SMALL_DEPTH(SMALL_DEPTH),
    .BYTE_LIMIT(8), .HALF_LIMIT(16), .CNT_W(CNT_W)
  ) u_depth (
    .big_en(cfg_big_fifo), .frame_bits(cfg_frame_bits), .depth(depth)
  );

  // lane 0 carries transmit words, lane 1 receive words
  assign l_flush[0]     = tx_flush;
  assign l_in_valid[0]  = tx_in_valid;
  assign l_in_data[0]   = tx_in_data;
  assign l_out_ready[0] = tx_out_ready;
  assign l_flush[1]     = rx_flush;
  assign l_in_valid[1]  = rx_in_valid;
  assign l_in_data[1]   = rx_in_data;
  assign l_out_ready[1] = rx_out_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dff_lane #(.DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .flush(l_flush[g]), .depth(depth),
      .in_valid(l_in_valid[g]), .in_ready(l_in_ready[g]), .in_data(l_in_data[g]),
      .out_valid(l_out_valid[g]), .out_ready(l_out_ready[g]),
      .out_data(l_out_data[g]), .count(l_count[g])
    );
    dff_flags #(.CNT_W(CNT_W)) u_flags (
      .count(l_count[g]), .depth(depth), .flags(l_flags[g])
    );
  end

  assign tx_in_ready  = l_in_ready[0];
  assign tx_out_valid = l_out_valid[0];
  assign tx_out_data  = l_out_data[0];
  assign tx_empty     = l_flags[0].empty;
  assign tx_empty_nxt = l_flags[0].empty_nxt;
  assign tx_full      = l_flags[0].full;
  assign tx_full_nxt  = l_flags[0].full_nxt;
  assign rx_in_ready  = l_in_ready[1];
  assign rx_out_valid = l_out_valid[1];
  assign rx_out_data  = l_out_data[1];
  assign rx_empty     = l_flags[1].empty;
  assign rx_empty_nxt = l_flags[1].empty_nxt;
  assign rx_full      = l_flags[1].full;
  assign rx_full_nxt  = l_flags[1].full_nxt;
endmodule

// File: rtl/dual_frame_fifo_chk.sv
module dual_frame_fifo_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_flush,
  input logic              tx_in_ready,
  input logic              tx_out_valid,
  input logic              tx_empty,
  input logic              tx_full,
  input logic              tx_full_nxt,
  input logic              rx_flush,
  input logic              rx_in_valid,
  input logic              rx_in_ready,
  input logic              rx_out_valid,
  input logic              rx_out_ready,
  input logic [DATA_W-1:0] rx_out_data,
  input logic              rx_empty,
  input logic              rx_empty_nxt,
  input logic              rx_full
);
  a_r4_tx_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_in_ready);
  a_r4_rx_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_in_ready);
  a_r5_nxt_below_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full_nxt |-> !tx_full);
  a_r6_empty_no_head: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> !tx_out_valid);
  a_r6_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty_nxt && rx_out_valid && rx_out_ready && !rx_in_valid && !rx_flush)
      |=> rx_empty);
  a_r7_tx_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_empty && !tx_full));
  a_r7_rx_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_empty && !rx_full));
  a_r8_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_out_valid |-> (rx_out_data == '0));
endmodule

bind dual_frame_fifo dual_frame_fifo_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dual_frame_fifo_bench.sv
module dual_frame_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big = 1'b0;
  logic [5:0]  fsz = 6'd8;
  logic        flush [2];
  logic        in_valid [2];
  logic        in_ready [2];
  logic [31:0] in_data [2];
  logic        out_valid [2];
  logic        out_ready [2];
  logic [31:0] out_data [2];
  logic        empty [2];
  logic        empty_nxt [2];
  logic        full [2];
  logic        full_nxt [2];

  logic [31:0] q_tx [$];
  logic [31:0] q_rx [$];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dual_frame_fifo u_dual_frame_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_big_fifo(big), .cfg_frame_bits(fsz),
    .tx_flush(flush[0]), .tx_in_valid(in_valid[0]), .tx_in_ready(in_ready[0]),
    .tx_in_data(in_data[0]), .tx_out_valid(out_valid[0]), .tx_out_ready(out_ready[0]),
    .tx_out_data(out_data[0]), .tx_empty(empty[0]), .tx_empty_nxt(empty_nxt[0]),
    .tx_full(full[0]), .tx_full_nxt(full_nxt[0]),
    .rx_flush(flush[1]), .rx_in_valid(in_valid[1]), .rx_in_ready(in_ready[1]),
    .rx_in_data(in_data[1]), .rx_out_valid(out_valid[1]), .rx_out_ready(out_ready[1]),
    .rx_out_data(out_data[1]), .rx_empty(empty[1]), .rx_empty_nxt(empty_nxt[1]),
    .rx_full(full[1]), .rx_full_nxt(full_nxt[1])
  );

  function automatic int q_size(int l);
    return (l == 0) ? q_tx.size() : q_rx.size();
  endfunction

  function automatic int depth_m();
    if (!big) return 4;
    if (fsz <= 6'd8) return 32;
    if (fsz <= 6'd16) return 16;
    return 8;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // driver: offers one word, predicts acceptance, records it in the scoreboard
  task automatic push(input int l, input logic [31:0] d);
    bit acc;
    @(posedge clk); #1;
    in_valid[l] = 1'b1;
    in_data[l]  = d;
    @(negedge clk);
    acc = q_size(l) < depth_m();
    chk(in_ready[l] == acc, "R4 ready", 32'(in_ready[l]), 32'(acc));
    if (acc) begin
      if (l == 0) q_tx.push_back(d); else q_rx.push_back(d);
    end
    @(posedge clk); #1;
    in_valid[l] = 1'b0;
  endtask

  task automatic flags(input int l, input string req);
    int n, d;
    @(negedge clk);
    n = q_size(l);
    d = depth_m();
    chk(empty[l] == (n == 0), {req, " empty"}, 32'(empty[l]), 32'(n == 0));
    chk(empty_nxt[l] == (n == 1), {req, " empty_nxt"}, 32'(empty_nxt[l]), 32'(n == 1));
    chk(full[l] == (n >= d), {req, " full"}, 32'(full[l]), 32'(n >= d));
    chk(full_nxt[l] == (n == d - 1), {req, " full_nxt"}, 32'(full_nxt[l]), 32'(n == d - 1));
  endtask

  task automatic drain_to(input int l, input int target);
    @(posedge clk); #1;
    out_ready[l] = 1'b1;
    for (int i = 0; i < 64 && q_size(l) > target; i++) begin
      @(posedge clk); #1;
    end
    out_ready[l] = 1'b0;
  endtask

  task automatic do_flush(input int l);
    @(posedge clk); #1;
    flush[l]    = 1'b1;
    in_valid[l] = 1'b1;
    in_data[l]  = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    flush[l]    = 1'b0;
    in_valid[l] = 1'b0;
    if (l == 0) q_tx.delete(); else q_rx.delete();
  endtask

  // monitor: compares every popped word with the scoreboard head (R9)
  always begin
    @(negedge clk); #1;
    for (int l = 0; l < 2; l++) begin
      if (rst_n && out_valid[l] && out_ready[l]) begin
        if (q_size(l) == 0) begin
          chk(1'b0, "R9 unexpected word", out_data[l], 32'h0);
        end else if (l == 0) begin
          chk(out_data[0] == q_tx[0], "R9 tx order", out_data[0], q_tx[0]);
          void'(q_tx.pop_front());
        end else begin
          chk(out_data[1] == q_rx[0], "R9 rx order", out_data[1], q_rx[0]);
          void'(q_rx.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < 2; l++) begin
      flush[l] = 1'b0; in_valid[l] = 1'b0; in_data[l] = '0; out_ready[l] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int l = 0; l < 2; l++) begin
      flags(l, "R1");
      chk(in_ready[l] == 1'b1, "R1 in_ready", 32'(in_ready[l]), 32'd1);
      chk(out_valid[l] == 1'b0, "R1 out_valid", 32'(out_valid[l]), 32'd0);
    end

    // R2 small depth, R4 drop, R5 flags near full
    big = 1'b0; fsz = 6'd8;
    for (int i = 0; i < 3; i++) push(0, 32'h100 + i);
    flags(0, "R5 at 3");
    push(0, 32'h103);
    flags(0, "R2 at 4");
    push(0, 32'h104);
    flags(0, "R4 after drop");
    drain_to(0, 0);
    flags(0, "R6 drained");

    // R3 depth 32, then R10 shrink to 16 and 8
    big = 1'b1; fsz = 6'd8;
    for (int i = 0; i < 31; i++) push(1, 32'h2000 + i);
    flags(1, "R3 at 31");
    push(1, 32'h201F);
    push(1, 32'h2020);
    flags(1, "R3 full 32");
    @(posedge clk); #1 fsz = 6'd16;
    flags(1, "R10 shrink16");
    chk(in_ready[1] == 1'b0, "R10 ready low", 32'(in_ready[1]), 32'd0);
    drain_to(1, 16);
    flags(1, "R10 at depth");
    drain_to(1, 15);
    flags(1, "R10 below depth");
    chk(in_ready[1] == 1'b1, "R10 ready back", 32'(in_ready[1]), 32'd1);
    @(posedge clk); #1 fsz = 6'd20;
    flags(1, "R3 depth 8");
    drain_to(1, 7);
    flags(1, "R3 full_nxt 8");
    drain_to(1, 0);

    // R3 depth 8 on transmit lane
    for (int i = 0; i < 9; i++) push(0, 32'h3000 + i);
    flags(0, "R3 tx depth 8");

    // R7 flush beats a same-cycle push
    do_flush(0);
    flags(0, "R7 flushed");
    push(0, 32'h4444);
    flags(0, "R6 one word");
    drain_to(0, 0);

    // R8 pop from empty
    @(posedge clk); #1 out_ready[1] = 1'b1;
    @(negedge clk);
    chk(out_valid[1] == 1'b0, "R8 out_valid", 32'(out_valid[1]), 32'd0);
    chk(out_data[1] == 32'h0, "R8 out_data", out_data[1], 32'h0);
    repeat (2) @(posedge clk);
    #1 out_ready[1] = 1'b0;
    flags(1, "R8 still empty");
    push(1, 32'h5555);
    flags(1, "R8 one after");
    drain_to(1, 0);

    // R9 simultaneous push and pop
    big = 1'b0;
    push(0, 32'hA);
    push(0, 32'hB);
    @(posedge clk); #1;
    in_valid[0] = 1'b1; in_data[0] = 32'hC; out_ready[0] = 1'b1;
    @(negedge clk);
    chk(in_ready[0] == 1'b1, "R9 ready", 32'(in_ready[0]), 32'd1);
    q_tx.push_back(32'hC);
    @(posedge clk); #1;
    in_valid[0] = 1'b0; out_ready[0] = 1'b0;
    flags(0, "R9 both");
    drain_to(0, 0);
    flags(0, "R6 end");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule